// File: doc/BRIEF.md
# Serial Flash Host Port

This block is the host side of a serial flash controller. Software sees a small register window with a control word, an interrupt mask, a status word and four data windows. Behind the data windows sit a transmit byte queue and a receive byte queue, each 16 entries deep. On the core side, the serial engine pops transmit bytes from a valid/ready stream and pushes receive bytes through a valid strobe. It also reports transmit-done and receive-done pulses and an idle level.

Each data window can move one byte or a packed 32-bit word. A wide flag in the control word selects the packed mode for the two word windows. In a packed word the byte at the head of the queue sits in bits 7:0, the next byte in bits 15:8, and so on. The status word holds four sticky events, which software clears by writing ones to them, plus several live conditions. A single registered interrupt output is raised when any status condition is set and enabled in the mask. Bus accesses take one cycle, and read data appears registered on the cycle after the read strobe.

Top module: `sfp_host_port`

## Requirements
- R1: After reset, status (offset 0x08) reads 0x090 with the engine idle, meaning receive-empty (bit 4) and ready (bit 7) are set. The interrupt output is low and no transmit byte is offered.
- R2: A write to the transmit byte window (0x44) queues bits 7:0 of the write data. The engine receives the queued bytes in write order on `eng_tx_byte` while `eng_tx_valid` is high, and takes one byte per cycle in which `eng_tx_ready` is also high.
- R3: When the wide flag (control bit 1) is set, a write to the transmit word window (0x4C) queues four bytes, starting with bits 7:0 and ending with bits 31:24.
- R4: A wide transmit word write with fewer than four free entries is dropped entirely. A byte write to a full queue is dropped. Status bit 5 (transmit full) is set exactly when 16 bytes are queued.
- R5: A read of the receive byte window (0x40) pops one byte and returns it in bits 7:0 with bits 31:8 zero. If the receive queue is empty, the read returns 0.
- R6: When the wide flag is set, a read of the receive word window (0x48) pops up to four bytes, with the oldest byte in bits 7:0. If fewer than four bytes are present, the missing upper bytes read as zero.
- R7: When the wide flag is clear, the word windows behave like the byte windows and move one byte in bits 7:0.
- R8: Status bit 0 (transmit done) and bit 1 (receive done) are set by the engine's done pulses. Status bits 0 to 3 are cleared by writing 1 to them. Writing 0 to a bit leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R9: Status bit 2 is set when a byte enters an empty receive queue. Status bit 3 is set when the engine takes a byte from a full transmit queue.
- R10: The interrupt-enable register (0x04, bits 5:0) uses the same bit positions as status bits 5:0. The interrupt output is the OR of the enabled, set status bits and follows a status change by one cycle.
- R11: Status bit 7 reads the engine idle level. Status bit 8 reads the wide flag.
- R12: While the enable bit (control bit 0) is clear, both queues are held empty, and host writes and engine receive bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe; data returned next cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |
| eng_tx_byte | output | 8 | Transmit byte at queue head |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_ready | input | 1 | Engine takes the head byte |
| eng_rx_byte | input | 8 | Received byte from engine |
| eng_rx_valid | input | 1 | Engine delivers a byte |
| eng_tx_done | input | 1 | Transmit phase complete pulse |
| eng_rx_done | input | 1 | Frame complete pulse |
| eng_idle | input | 1 | Engine has no frame in progress |

## Verification
A corrupted queue pointer or count shows up at the ports within a single access. The engine would see a byte out of order, a packed word would carry the wrong lane, or the full and empty status bits would disagree with the number of bytes written. The queues are driven to exactly 13 and exactly 16 entries, so an off-by-one in the free-space test makes a dropped word reappear in the drained byte sequence. A wrong sticky event or a mask mix-up appears on `irq` one cycle after the status change, and the interrupt is checked at that cycle both masked and unmasked.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // register byte offsets
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_IEN  = 'h04;
  localparam int unsigned OFS_STAT = 'h08;
  localparam int unsigned OFS_RXB  = 'h40;
  localparam int unsigned OFS_TXB  = 'h44;
  localparam int unsigned OFS_RXW  = 'h48;
  localparam int unsigned OFS_TXW  = 'h4C;

  // control bits
  localparam int unsigned CTL_EN   = 0;
  localparam int unsigned CTL_WIDE = 1;

  // status bits; events 0..3 are sticky
  localparam int unsigned ST_TXDONE  = 0;
  localparam int unsigned ST_RXDONE  = 1;
  localparam int unsigned ST_RXAVAIL = 2;
  localparam int unsigned ST_TXSPACE = 3;
  localparam int unsigned ST_RXEMPTY = 4;
  localparam int unsigned ST_TXFULL  = 5;
  localparam int unsigned ST_READY   = 7;
  localparam int unsigned ST_WIDE    = 8;

  localparam int unsigned N_EVENTS = 4;
  localparam int unsigned N_IRQ    = 6;
endpackage

// File: rtl/sfp_byte_fifo.sv
// Byte queue with multi-byte push and pop per cycle. DEPTH must be a power of two.
module sfp_byte_fifo #(
  parameter int unsigned DEPTH    = 16,
  parameter int unsigned WR_LANES = 4,
  parameter int unsigned RD_LANES = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic [$clog2(WR_LANES+1)-1:0] push_cnt,
  input  logic [8*WR_LANES-1:0]        push_data,
  input  logic [$clog2(RD_LANES+1)-1:0] pop_cnt,
  output logic [8*RD_LANES-1:0]        head_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned CW  = $clog2(DEPTH+1);
  localparam int unsigned WLW = $clog2(WR_LANES+1);
  localparam int unsigned RLW = $clog2(RD_LANES+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;

  // storage: no reset, so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(WR_LANES); k++) begin
      if (WLW'(k) < push_cnt) mem[wptr_q + AW'(k)] <= push_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= wptr_q + AW'(push_cnt);
      rptr_q  <= rptr_q + AW'(pop_cnt);
      count_q <= count_q + CW'(push_cnt) - CW'(pop_cnt);
    end
  end

  for (genvar g = 0; g < int'(RD_LANES); g++) begin : g_head
    assign head_data[8*g +: 8] = mem[rptr_q + AW'(g)];
  end

  assign count = count_q;

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  p_full_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (count_q == CW'(DEPTH) && pop_cnt == '0 && !flush) |=> count_q == CW'(DEPTH));
  p_flush_empty_r12: assert property (@(posedge clk) disable iff (rst)
    flush |=> count_q == '0);
endmodule

// File: rtl/sfp_status.sv
// Sticky write-one-to-clear events and the registered interrupt.
module sfp_status #(
  parameter int unsigned NEV  = 4,
  parameter int unsigned NIRQ = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEV-1:0]  ev_set,
  input  logic [NEV-1:0]  ev_clr,
  input  logic [NIRQ-NEV-1:0] live,
  input  logic [NIRQ-1:0] ien,
  output logic [NEV-1:0]  ev_q,
  output logic            irq
);
  logic [NEV-1:0] ev_r;
  logic           irq_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_r  <= '0;
      irq_r <= 1'b0;
    end else begin
      ev_r  <= (ev_r & ~ev_clr) | ev_set;
      irq_r <= |(ien & {live, ev_r});
    end
  end

  assign ev_q = ev_r;
  assign irq  = irq_r;

  for (genvar g = 0; g < int'(NEV); g++) begin : g_chk
    p_set_r8: assert property (@(posedge clk) disable iff (rst)
      ev_set[g] |=> ev_r[g]);
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
      (ev_clr[g] && !ev_set[g]) |=> !ev_r[g]);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!ev_clr[g] && !ev_set[g]) |=> ev_r[g] == $past(ev_r[g]));
  end
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq_r);
endmodule

// File: rtl/sfp_host_port.sv
module sfp_host_port
  import sfp_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_we,
  input  logic                    reg_re,
  input  logic [8*WORD_BYTES-1:0] reg_wdata,
  output logic [8*WORD_BYTES-1:0] reg_rdata,
  output logic                    irq,
  output logic [7:0]              eng_tx_byte,
  output logic                    eng_tx_valid,
  input  logic                    eng_tx_ready,
  input  logic [7:0]              eng_rx_byte,
  input  logic                    eng_rx_valid,
  input  logic                    eng_tx_done,
  input  logic                    eng_rx_done,
  input  logic                    eng_idle
);
  localparam int unsigned DW = 8*WORD_BYTES;
  localparam int unsigned CW = $clog2(FIFO_DEPTH+1);
  localparam int unsigned LW = $clog2(WORD_BYTES+1);

  // ---------------- address decode ----------------
  logic hit_ctrl, hit_ien, hit_stat, hit_rxb, hit_txb, hit_rxw, hit_txw;
  assign hit_ctrl = reg_addr == ADDR_W'(OFS_CTRL);
  assign hit_ien  = reg_addr == ADDR_W'(OFS_IEN);
  assign hit_stat = reg_addr == ADDR_W'(OFS_STAT);
  assign hit_rxb  = reg_addr == ADDR_W'(OFS_RXB);
  assign hit_txb  = reg_addr == ADDR_W'(OFS_TXB);
  assign hit_rxw  = reg_addr == ADDR_W'(OFS_RXW);
  assign hit_txw  = reg_addr == ADDR_W'(OFS_TXW);

  // ---------------- control and mask ----------------
  logic              en_q, wide_q;
  logic [N_IRQ-1:0]  ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      wide_q <= 1'b0;
      ien_q  <= '0;
    end else if (reg_we) begin
      if (hit_ctrl) begin
        en_q   <= reg_wdata[CTL_EN];
        wide_q <= reg_wdata[CTL_WIDE];
      end
      if (hit_ien) ien_q <= reg_wdata[N_IRQ-1:0];
    end
  end

  // ---------------- transmit queue ----------------
  logic [CW-1:0] tx_cnt, tx_free;
  logic [LW-1:0] tx_push;
  logic          tx_pop;
  logic [7:0]    tx_head;

  assign tx_free = CW'(FIFO_DEPTH) - tx_cnt;

  always_comb begin
    tx_push = '0;
    if (en_q && reg_we) begin
      if (hit_txw && wide_q)
        tx_push = (tx_free >= CW'(WORD_BYTES)) ? LW'(WORD_BYTES) : '0;
      else if (hit_txb || hit_txw)
        tx_push = (tx_free != '0) ? LW'(1) : '0;
    end
  end

  assign tx_pop       = eng_tx_ready && (tx_cnt != '0);
  assign eng_tx_valid = tx_cnt != '0;
  assign eng_tx_byte  = tx_head;

  sfp_byte_fifo #(
    .DEPTH(FIFO_DEPTH), .WR_LANES(WORD_BYTES), .RD_LANES(1)
  ) u_txq (
    .clk      (clk),
    .rst      (rst),
    .flush    (!en_q),
    .push_cnt (tx_push),
    .push_data(reg_wdata),
    .pop_cnt  (tx_pop),
    .head_data(tx_head),
    .count    (tx_cnt)
  );

  // ---------------- receive queue ----------------
  logic [CW-1:0] rx_cnt;
  logic          rx_push;
  logic [LW-1:0] rx_pop;
  logic [DW-1:0] rx_head, rx_word;

  assign rx_push = en_q && eng_rx_valid && (rx_cnt != CW'(FIFO_DEPTH));

  always_comb begin
    rx_pop = '0;
    if (reg_re) begin
      if (hit_rxw && wide_q)
        rx_pop = (rx_cnt >= CW'(WORD_BYTES)) ? LW'(WORD_BYTES) : LW'(rx_cnt);
      else if (hit_rxb || hit_rxw)
        rx_pop = (rx_cnt != '0) ? LW'(1) : '0;
    end
  end

  // lanes beyond the bytes popped read as zero
  always_comb begin
    rx_word = '0;
    for (int k = 0; k < int'(WORD_BYTES); k++) begin
      if (LW'(k) < rx_pop) rx_word[8*k +: 8] = rx_head[8*k +: 8];
    end
  end

  sfp_byte_fifo #(
    .DEPTH(FIFO_DEPTH), .WR_LANES(1), .RD_LANES(WORD_BYTES)
  ) u_rxq (
    .clk      (clk),
    .rst      (rst),
    .flush    (!en_q),
    .push_cnt (rx_push),
    .push_data(eng_rx_byte),
    .pop_cnt  (rx_pop),
    .head_data(rx_head),
    .count    (rx_cnt)
  );

  // ---------------- status and interrupt ----------------
  logic [N_EVENTS-1:0] ev_set, ev_clr, ev_q;
  logic                rx_empty, tx_full;

  assign rx_empty = rx_cnt == '0;
  assign tx_full  = tx_cnt == CW'(FIFO_DEPTH);

  always_comb begin
    ev_set             = '0;
    ev_set[ST_TXDONE]  = eng_tx_done;
    ev_set[ST_RXDONE]  = eng_rx_done;
    ev_set[ST_RXAVAIL] = rx_push && rx_empty;
    ev_set[ST_TXSPACE] = tx_pop && tx_full;
  end
  assign ev_clr = (reg_we && hit_stat) ? reg_wdata[N_EVENTS-1:0] : '0;

  sfp_status #(.NEV(N_EVENTS), .NIRQ(N_IRQ)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .ev_set(ev_set),
    .ev_clr(ev_clr),
    .live  ({tx_full, rx_empty}),
    .ien   (ien_q),
    .ev_q  (ev_q),
    .irq   (irq)
  );

  // ---------------- read data ----------------
  logic [DW-1:0] stat_word, rd_next, rdata_q;

  always_comb begin
    stat_word             = '0;
    stat_word[N_EVENTS-1:0] = ev_q;
    stat_word[ST_RXEMPTY] = rx_empty;
    stat_word[ST_TXFULL]  = tx_full;
    stat_word[ST_READY]   = eng_idle;
    stat_word[ST_WIDE]    = wide_q;
  end

  always_comb begin
    rd_next = '0;
    if (hit_ctrl) begin
      rd_next[CTL_EN]   = en_q;
      rd_next[CTL_WIDE] = wide_q;
    end else if (hit_ien) begin
      rd_next[N_IRQ-1:0] = ien_q;
    end else if (hit_stat) begin
      rd_next = stat_word;
    end else if (hit_rxb || hit_rxw) begin
      rd_next = rx_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_next;
  end
  assign reg_rdata = rdata_q;

  p_byte_read_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_re && hit_rxb) |=> reg_rdata[DW-1:8] == '0);
  p_word_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && hit_txw && wide_q && tx_free < CW'(WORD_BYTES) && !tx_pop)
      |=> $stable(tx_cnt));
  p_disabled_r12: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !eng_tx_valid);
endmodule

// File: tb/tb_sfp_host_port.sv
module tb_sfp_host_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [7:0]  eng_tx_byte;
  logic        eng_tx_valid;
  logic        eng_tx_ready = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_rx_valid = 1'b0;
  logic        eng_tx_done = 1'b0, eng_rx_done = 1'b0;
  logic        eng_idle = 1'b1;

  int total = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfp_host_port dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .eng_tx_byte(eng_tx_byte), .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready),
    .eng_rx_byte(eng_rx_byte), .eng_rx_valid(eng_rx_valid),
    .eng_tx_done(eng_tx_done), .eng_rx_done(eng_rx_done), .eng_idle(eng_idle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pull(output logic v, output logic [7:0] b);
    @(negedge clk);
    v = eng_tx_valid; b = eng_tx_byte; eng_tx_ready = 1'b1;
    @(negedge clk);
    eng_tx_ready = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    eng_rx_byte = b; eng_rx_valid = 1'b1;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, eng_tx_valid}, 32'h0);
    rd(8'h08, d);
    chk("R1 status", d, 32'h090);
  endtask

  task automatic t_tx_byte;
    logic v; logic [7:0] b;
    wr(8'h00, 32'h1);
    wr(8'h44, 32'hFFFF_FFA5);
    wr(8'h44, 32'h1234_563C);
    pull(v, b); chk("R2 byte0", {23'b0, v, b}, {23'b0, 1'b1, 8'hA5});
    pull(v, b); chk("R2 byte1", {23'b0, v, b}, {23'b0, 1'b1, 8'h3C});
    pull(v, b); chk("R2 empty", {31'b0, v}, 32'h0);
  endtask

  task automatic t_tx_word;
    logic v; logic [7:0] b;
    wr(8'h00, 32'h3);
    wr(8'h4C, 32'h4433_2211);
    for (int i = 0; i < 4; i++) begin
      pull(v, b);
      chk("R3 lane", {23'b0, v, b}, {23'b0, 1'b1, 8'(8'h11 * (i + 1))});
    end
    pull(v, b); chk("R3 empty", {31'b0, v}, 32'h0);
  endtask

  task automatic t_tx_full;
    logic v; logic [7:0] b; logic [31:0] d;
    wr(8'h00, 32'h3);
    wr(8'h4C, 32'h0302_0100);
    wr(8'h4C, 32'h0706_0504);
    wr(8'h4C, 32'h0B0A_0908);
    wr(8'h44, 32'h0C);
    wr(8'h4C, 32'hDEAD_BEEF);          // 3 free: dropped
    wr(8'h44, 32'h0D);
    wr(8'h44, 32'h0E);
    wr(8'h44, 32'h0F);
    wr(8'h44, 32'h77);                 // full: dropped
    rd(8'h08, d);
    chk("R4 full status", d, 32'h1B0);
    for (int i = 0; i < 16; i++) begin
      pull(v, b);
      chk("R4 drain", {23'b0, v, b}, {23'b0, 1'b1, 8'(i)});
    end
    pull(v, b); chk("R4 no extra", {31'b0, v}, 32'h0);
    rd(8'h08, d);
    chk("R9 tx space", d, 32'h198);
    wr(8'h08, 32'h8);
    rd(8'h08, d);
    chk("R8 w1c space", d, 32'h190);
  endtask

  task automatic t_rx;
    logic [31:0] d; logic v; logic [7:0] b;
    wr(8'h00, 32'h1);
    rd(8'h40, d); chk("R5 empty read", d, 32'h0);
    push(8'h5A);
    rd(8'h08, d); chk("R9 rx avail", d, 32'h084);
    push(8'h6B);
    rd(8'h40, d); chk("R5 byte", d, 32'h5A);
    rd(8'h48, d); chk("R7 rx narrow", d, 32'h6B);
    wr(8'h08, 32'h4);
    rd(8'h08, d); chk("R8 w1c avail", d, 32'h090);
    wr(8'h4C, 32'hAABB_CCDD);
    pull(v, b); chk("R7 tx narrow", {23'b0, v, b}, {23'b0, 1'b1, 8'hDD});
    pull(v, b); chk("R7 tx one", {31'b0, v}, 32'h0);
    wr(8'h00, 32'h3);
    for (int i = 0; i < 6; i++) push(8'(8'h10 + i));
    rd(8'h48, d); chk("R6 word", d, 32'h1312_1110);
    rd(8'h48, d); chk("R6 pad", d, 32'h0000_1514);
    rd(8'h48, d); chk("R6 empty", d, 32'h0);
    wr(8'h08, 32'hF);
  endtask

  task automatic t_events;
    logic [31:0] d;
    wr(8'h04, 32'h0);
    @(negedge clk); eng_tx_done = 1'b1;
    @(negedge clk); eng_tx_done = 1'b0;
    @(negedge clk);
    chk("R10 masked", {31'b0, irq}, 32'h0);
    rd(8'h08, d); chk("R8 tx done", d & 32'hF, 32'h1);
    wr(8'h04, 32'h1);
    chk("R10 lag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 raised", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0);
    rd(8'h08, d); chk("R8 write zero", d & 32'hF, 32'h1);
    wr(8'h08, 32'h1);
    @(negedge clk);
    chk("R10 dropped", {31'b0, irq}, 32'h0);
    @(negedge clk);
    reg_addr = 8'h08; reg_wdata = 32'h2; reg_we = 1'b1; eng_rx_done = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; eng_rx_done = 1'b0;
    rd(8'h08, d); chk("R8 set wins", d & 32'hF, 32'h2);
    wr(8'h08, 32'h2);
    wr(8'h04, 32'h10);                 // rx empty condition
    @(negedge clk);
    chk("R10 live bit", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_ready;
    logic [31:0] d;
    wr(8'h00, 32'h3);
    eng_idle = 1'b0;
    rd(8'h08, d); chk("R11 busy wide", d, 32'h110);
    eng_idle = 1'b1;
    wr(8'h00, 32'h1);
    rd(8'h08, d); chk("R11 idle narrow", d, 32'h090);
  endtask

  task automatic t_flush;
    logic [31:0] d; logic v; logic [7:0] b;
    wr(8'h00, 32'h3);
    wr(8'h4C, 32'h1111_1111);
    push(8'h42);
    push(8'h43);
    wr(8'h00, 32'h0);
    wr(8'h44, 32'h99);
    push(8'h55);
    wr(8'h00, 32'h1);
    pull(v, b); chk("R12 tx flushed", {31'b0, v}, 32'h0);
    rd(8'h08, d); chk("R12 rx flushed", d & 32'h30, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_byte();
    t_tx_word();
    t_tx_full();
    t_rx();
    t_events();
    t_ready();
    t_flush();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule